// File: doc/BRIEF.md
# CAN Initialization Mode Handshake

This block decides when a CAN controller really is in its initialization mode and when it is running normally. Software asks for a mode through a single request level. The block answers with an acknowledge flag that follows the request only after the change has safely happened. It also drives an enable that lets the protocol engine run.

Entering initialization mode is safe only between frames. A request that arrives while a frame is on the wire is held back until the protocol engine reports that it is idle. Leaving initialization mode is safe only once the bus is idle. The block watches the sampled receive level on each bit-time strobe and returns to normal operation after it has seen eleven recessive samples in a row.

The controller has four states:
- `MODE_INIT`: in initialization mode. Acknowledge is 1 and the engine is disabled.
- `MODE_SYNC`: the request has been withdrawn and the block is counting recessive bits. It is still in initialization mode, so acknowledge is 1 and the engine is disabled.
- `MODE_RUN`: normal operation. Acknowledge is 0 and the engine is enabled.
- `MODE_DRAIN`: a request is pending while a frame is in progress. Acknowledge is 0 and the engine is enabled.

The transitions are:
- INIT→SYNC when the request is low.
- SYNC→INIT when the request is high again.
- SYNC→RUN when the recessive run is complete.
- RUN→INIT when the request is high and the engine is idle.
- RUN→DRAIN when the request is high and the engine is busy.
- DRAIN→RUN when the request is withdrawn.
- DRAIN→INIT when the engine goes idle.

Top module: `canmode_ctrl`

## Requirements
- R1: After reset the block is in initialization mode: `init_ack_o`=1 and `engine_en_o`=0.
- R2: In normal mode, with `frame_busy_i`=0, a high `init_req_i` sampled at a clock edge makes `init_ack_o` read 1 right after that edge.
- R3: While `frame_busy_i`=1, `init_ack_o` stays 0 even with the request high. It rises right after the first edge at which the request is high and `frame_busy_i`=0.
- R4: If the request drops while entry is deferred, the block stays in normal mode with `init_ack_o`=0. A later request again waits for `frame_busy_i`=0.
- R5: Once the request is low, `init_ack_o` stays 1 until 11 consecutive recessive samples (`rx_level_i`=1) have been taken on strobes. It reads 0 right after the edge that takes the 11th.
- R6: A dominant sample (`rx_level_i`=0) taken on a strobe restarts the run, so 11 fresh recessive samples are needed.
- R7: Cycles with `bit_tick_i`=0 neither count nor restart the run, whatever `rx_level_i` is.
- R8: A request raised while the run is being counted returns the block to plain initialization mode and discards the count. After the next withdrawal, a full 11-sample run is needed.
- R9: `engine_en_o` is 0 for every cycle in which `init_ack_o` is 1, and 1 in every other cycle.
- R10: `frame_busy_i` has no effect on leaving initialization mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_req_i | input | 1 | Software request: 1 asks for initialization mode |
| frame_busy_i | input | 1 | Protocol engine is sending or receiving a frame |
| rx_level_i | input | 1 | Sampled receive bus level, 1 = recessive |
| bit_tick_i | input | 1 | One-cycle strobe per bit time |
| init_ack_o | output | 1 | 1 while in initialization mode |
| engine_en_o | output | 1 | Enable for the protocol engine |

## Verification
The assertions assume that every input is synchronous to `clk` and stable across each edge. They also assume that `rx_level_i` is meaningful only in cycles where `bit_tick_i` is high. They do not assume that the busy indication drops within any bound, so a deferred entry may last any number of cycles. The stimulus changes inputs only on falling clock edges and raises the strobe for single cycles. It puts dominant levels on non-strobe cycles on purpose, to show that they are ignored.

// File: rtl/canmode_pkg.sv
package canmode_pkg;

    // Controller mode states
    typedef enum logic [1:0] {
        MODE_INIT  = 2'd0,
        MODE_SYNC  = 2'd1,
        MODE_RUN   = 2'd2,
        MODE_DRAIN = 2'd3
    } mode_e;

    // States in which the controller counts as being in initialization mode
    function automatic logic mode_is_init(input mode_e m);
        return (m == MODE_INIT) || (m == MODE_SYNC);
    endfunction

endpackage

// File: rtl/canmode_run_cnt.sv
module canmode_run_cnt #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic tick_i,
    input  logic level_i,
    output logic done_o
);
    localparam int CNT_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             hit_last;

    assign hit_last = (cnt_q == LAST);
    assign done_o   = enable_i && tick_i && level_i && hit_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (!level_i || hit_last) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R5: the stored run never passes the final position
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R7: no strobe, no change of the run
    p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !tick_i) |=> $stable(cnt_q));

    // R6: a dominant sample on a strobe restarts the run
    p_dominant_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && tick_i && !level_i) |=> (cnt_q == '0));

endmodule

// File: rtl/canmode_fsm.sv
module canmode_fsm
    import canmode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic busy_i,
    input  logic run_done_i,
    output logic ack_o,
    output logic en_o,
    output logic sync_o
);
    mode_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_INIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_INIT: begin
                if (!req_i) state_d = MODE_SYNC;
            end
            MODE_SYNC: begin
                if (req_i)           state_d = MODE_INIT;
                else if (run_done_i) state_d = MODE_RUN;
            end
            MODE_RUN: begin
                if (req_i) state_d = busy_i ? MODE_DRAIN : MODE_INIT;
            end
            MODE_DRAIN: begin
                if (!req_i)      state_d = MODE_RUN;
                else if (!busy_i) state_d = MODE_INIT;
            end
            default: state_d = MODE_INIT;
        endcase
    end

    // Output decode
    always_comb begin
        ack_o  = mode_is_init(state_q);
        en_o   = 1'b0;
        sync_o = 1'b0;
        unique case (state_q)
            MODE_INIT:  en_o = 1'b0;
            MODE_SYNC:  sync_o = 1'b1;
            MODE_RUN:   en_o = 1'b1;
            MODE_DRAIN: en_o = 1'b1;
            default:    en_o = 1'b0;
        endcase
    end

    // R9: engine enable and acknowledge are never both high or both low
    p_enable_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en_o != ack_o);

    // R3: no entry while a frame is in progress
    p_busy_defer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_o && busy_i) |=> !ack_o);

    // R2: request with idle engine enters initialization mode
    p_enter_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_o && req_i && !busy_i) |=> ack_o);

    // R5: acknowledge only clears after a completed run
    p_leave_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !run_done_i) |=> ack_o);

    // R4: withdrawing a deferred request keeps normal mode
    p_withdraw_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_DRAIN && !req_i) |=> (state_q == MODE_RUN));

    // R8: request during the run count returns to plain init mode
    p_sync_reenter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_o && req_i) |=> (ack_o && !sync_o));

endmodule

// File: rtl/canmode_ctrl.sv
module canmode_ctrl #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_req_i,
    input  logic frame_busy_i,
    input  logic rx_level_i,
    input  logic bit_tick_i,
    output logic init_ack_o,
    output logic engine_en_o
);
    logic sync_active;
    logic run_done;

    canmode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (init_req_i),
        .busy_i     (frame_busy_i),
        .run_done_i (run_done),
        .ack_o      (init_ack_o),
        .en_o       (engine_en_o),
        .sync_o     (sync_active)
    );

    canmode_run_cnt #(
        .RUN_LEN (IDLE_BITS)
    ) u_run_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (sync_active),
        .tick_i   (bit_tick_i),
        .level_i  (rx_level_i),
        .done_o   (run_done)
    );

    // R7: leaving init mode requires a strobe
    p_leave_needs_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (init_ack_o && !bit_tick_i) |=> init_ack_o);

    // R6: a dominant strobe sample never ends init mode
    p_dominant_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (init_ack_o && bit_tick_i && !rx_level_i) |=> init_ack_o);

endmodule

// File: tb/canmode_ctrl_bench.sv
module canmode_ctrl_bench;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b1;
    logic busy = 1'b0;
    logic rx = 1'b1;
    logic tick = 1'b0;
    logic ack;
    logic en;

    int checks = 0;
    int fails = 0;
    logic  exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    canmode_ctrl u_canmode_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_req_i   (req),
        .frame_busy_i (busy),
        .rx_level_i   (rx),
        .bit_tick_i   (tick),
        .init_ack_o   (ack),
        .engine_en_o  (en)
    );

    task automatic check_now(input logic exp_ack, input string tag);
        checks++;
        if (ack !== exp_ack || en !== ~exp_ack) begin
            fails++;
            $display("FAIL %s: ack=%b en=%b expected ack=%b en=%b",
                     tag, ack, en, exp_ack, ~exp_ack);
        end
    endtask

    // Driver: apply inputs for one cycle, queue expected outputs after the edge
    task automatic step(input logic r, input logic b, input logic lv,
                        input logic t, input logic exp_ack, input string tag);
        @(negedge clk);
        req  = r;
        busy = b;
        rx   = lv;
        tick = t;
        exp_q.push_back(exp_ack);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD / 4);
        if (exp_q.size() > 0) begin
            logic  e;
            string s;
            e = exp_q.pop_front();
            s = tag_q.pop_front();
            check_now(e, s);
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        #(CLK_PERIOD * 2);
        check_now(1'b1, "R1 during reset");
        @(negedge clk);
        rst_n = 1'b1;
        step(1, 0, 1, 0, 1'b1, "R1 after reset");
        step(1, 0, 1, 0, 1'b1, "R1 held");

        // R5: withdraw and count 11 recessive strobes
        step(0, 0, 1, 0, 1'b1, "R5 withdraw");
        for (int i = 1; i <= 11; i++) begin
            step(0, 0, 1, 1, (i < 11), "R5 recessive run");
        end
        step(0, 0, 1, 0, 1'b0, "R5 normal mode");

        // R2: enter with idle engine
        step(1, 0, 1, 0, 1'b1, "R2 enter");

        // R7: dominant non-strobe cycles are ignored
        step(0, 0, 1, 0, 1'b1, "R7 withdraw");
        for (int i = 1; i <= 5; i++) step(0, 0, 1, 1, 1'b1, "R7 first ticks");
        for (int i = 0; i < 3; i++)  step(0, 0, 0, 0, 1'b1, "R7 dominant no tick");
        for (int i = 6; i <= 11; i++) step(0, 0, 1, 1, (i < 11), "R7 rest of run");

        // R3: request deferred while busy
        for (int i = 0; i < 4; i++) step(1, 1, 1, 0, 1'b0, "R3 deferred");
        step(1, 0, 1, 0, 1'b1, "R3 entered after frame");

        // R6: dominant strobe restarts the run
        step(0, 0, 1, 0, 1'b1, "R6 withdraw");
        for (int i = 0; i < 7; i++) step(0, 0, 1, 1, 1'b1, "R6 partial run");
        step(0, 0, 0, 1, 1'b1, "R6 dominant strobe");
        for (int i = 1; i <= 11; i++) step(0, 0, 1, 1, (i < 11), "R6 fresh run");

        // R4: withdraw during deferral
        step(1, 1, 1, 0, 1'b0, "R4 deferred");
        step(1, 1, 1, 0, 1'b0, "R4 deferred");
        step(0, 1, 1, 0, 1'b0, "R4 withdrawn");
        step(0, 0, 1, 0, 1'b0, "R4 stays normal");
        step(1, 1, 1, 0, 1'b0, "R4 new request waits");
        step(1, 0, 1, 0, 1'b1, "R4 entered");

        // R8 and R10: re-request during count, busy ignored
        step(0, 1, 1, 0, 1'b1, "R8 withdraw");
        for (int i = 0; i < 8; i++) step(0, 1, 1, 1, 1'b1, "R8 partial run");
        step(1, 1, 1, 0, 1'b1, "R8 re-request");
        step(0, 1, 1, 0, 1'b1, "R8 withdraw again");
        for (int i = 1; i <= 11; i++) step(0, 1, 1, 1, (i < 11), "R10 full run with busy");
        step(0, 0, 1, 0, 1'b0, "R9 normal enable");

        @(posedge clk);
        #(CLK_PERIOD / 2);
        finish_run();
    end
endmodule